// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the 32 input pins of a general-purpose I/O port and turns selected pin activity into one interrupt request. Each pin has its own trigger condition: a rising edge, a falling edge, any transition, a high level or a low level. Three per-pin configuration words choose the condition: a mode word (edge or level), a polarity word, and an any-edge word. Per-pin enable and mask words control which pins take part.

Pin inputs are asynchronous. Each passes through a two-flop synchroniser before it is examined. Edge events are latched in a raw status word until software writes a 1 to that pin's position in the clear word. Level-mode pins report the live active level. A masked status word hides masked pins, and the OR of its bits drives the interrupt output.

Software reaches every word through a single-cycle register port: a write strobe with an address and data, and a combinational read.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every configuration word, the raw status and the masked status read as zero, and `irq_o` is low.
- R2: In edge mode, a pin event sets its raw status bit only while the pin's enable bit is 1. A bit that is already latched stays set after its enable is cleared. A level-mode pin with its enable bit at 0 reports 0.
- R3: With mode bit 0 and any-edge bit 0, a polarity bit of 0 latches on a rising edge and a polarity bit of 1 latches on a falling edge.
- R4: With mode bit 0 and any-edge bit 1, every transition of the pin latches its raw bit, whatever the polarity bit holds.
- R5: With mode bit 1, the raw bit follows the synchronised pin: active high for polarity 0 and active low for polarity 1. It drops again once the level goes away.
- R6: Writing to offset 0x30 clears the latched edge bit of each pin whose data bit is 1. Pins written with 0 keep their state. A new edge event in the same cycle as its clear leaves the bit set. Clearing has no lasting effect on level-mode pins.
- R7: Masked status equals raw status AND NOT mask, where a mask bit of 1 hides the pin. `irq_o` is the OR of the masked status bits.
- R8: A pin change applied between clock edges first shows in the raw status after the third rising clock edge: two synchroniser stages plus the status register.
- R9: The byte offsets are: enable 0x20, raw status 0x24, masked status 0x28, mask 0x2C, clear 0x30, mode 0x34, any-edge 0x38, polarity 0x3C. Reading the clear offset or an unmapped offset returns 0. Writes to the two status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous pin inputs |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong synchroniser or previous-value flop shows up as a raw status bit that is missing, spurious, or one cycle early or late. That difference is visible at the read port within three clock edges of the pin change. A wrong clear or latch term leaves a raw bit stale until the next clear. This is why the raw status is read and compared every idle cycle, along with `irq_o`. Configuration decode faults appear at the next pin transition that exercises the mis-decoded mode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_EN    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_MSKD  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_MODE  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_ANY   = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_POL   = 8'h3C;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_s_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] any_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] raw_o
);
  logic [WIDTH-1:0] prev_q, raw_q;
  logic [WIDTH-1:0] rise, fall, evt, act;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_s_i;

  always_comb begin
    rise = pin_s_i & ~prev_q;
    fall = ~pin_s_i & prev_q;
    evt  = en_i & ((any_i & (rise | fall)) |
                   (~any_i & pol_i & fall) |
                   (~any_i & ~pol_i & rise));
    act  = en_i & (pin_s_i ^ pol_i);
  end

  // level pins track, edge pins latch; a new event beats its own clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (mode_i & act) | (~mode_i & ((raw_q & ~clr_i) | evt));

  assign raw_o = raw_q;

  a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~mode_i & ~evt) != '0) |=> ((raw_q & $past(clr_i & ~mode_i & ~evt)) == '0));

  a_r2_edge_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mode_i & ~en_i & ~raw_q) != '0) |=> ((raw_q & $past(~mode_i & ~en_i & ~raw_q)) == '0));

  a_r5_level_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i & ~en_i) != '0) |=> ((raw_q & $past(mode_i & ~en_i)) == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  raw_i,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  mode_o,
  output logic [WIDTH-1:0]  any_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] en_q, mask_q, mode_q, any_q, pol_q, masked;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      mode_q <= '0;
      any_q  <= '0;
      pol_q  <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFF_EN:   en_q   <= wdata_i;
        OFF_MASK: mask_q <= wdata_i;
        OFF_MODE: mode_q <= wdata_i;
        OFF_ANY:  any_q  <= wdata_i;
        OFF_POL:  pol_q  <= wdata_i;
        default: ;
      endcase
    end

  assign clr_o  = (wr_en_i && addr_i == OFF_CLR) ? wdata_i : '0;
  assign masked = raw_i & ~mask_q;
  assign irq_o  = |masked;

  always_comb begin
    unique case (addr_i)
      OFF_EN:   rdata_o = en_q;
      OFF_RAW:  rdata_o = raw_i;
      OFF_MSKD: rdata_o = masked;
      OFF_MASK: rdata_o = mask_q;
      OFF_MODE: rdata_o = mode_q;
      OFF_ANY:  rdata_o = any_q;
      OFF_POL:  rdata_o = pol_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign any_o  = any_q;
  assign pol_o  = pol_q;

  a_r7_mask_all_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_MASK && (&wdata_i)) |=> !irq_o);

  a_r9_status_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == OFF_RAW || addr_i == OFF_MSKD)) |=>
      ($stable(en_q) && $stable(mask_q) && $stable(mode_q) && $stable(any_q) && $stable(pol_q)));

  a_r9_clear_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_CLR) |-> (rdata_o == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] pin_s, en, mode, any, pol, clr, raw;

  gpio_irq_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  gpio_irq_detect #(.WIDTH(WIDTH)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_s_i(pin_s),
    .en_i   (en),
    .mode_i (mode),
    .any_i  (any),
    .pol_i  (pol),
    .clr_i  (clr),
    .raw_o  (raw)
  );

  gpio_irq_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .raw_i  (raw),
    .en_o   (en),
    .mode_o (mode),
    .any_o  (any),
    .pol_o  (pol),
    .clr_o  (clr),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
  localparam logic [7:0] A_EN = 8'h20, A_RAW = 8'h24, A_MSKD = 8'h28, A_MASK = 8'h2C,
                         A_CLR = 8'h30, A_MODE = 8'h34, A_ANY = 8'h38, A_POL = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = A_RAW;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_s1, m_s2, m_prev, m_raw, m_en, m_mask, m_mode, m_any, m_pol;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [31:0] clr;
    logic [31:0] nraw;
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_raw <= '0;
      m_en <= '0; m_mask <= '0; m_mode <= '0; m_any <= '0; m_pol <= '0;
    end else begin
      clr = (wr_en && addr == A_CLR) ? wdata : 32'h0;
      for (int i = 0; i < 32; i++) begin
        bit ev;
        if (m_mode[i]) begin
          nraw[i] = m_en[i] && (m_pol[i] ? !m_s2[i] : m_s2[i]);
        end else begin
          if (m_any[i])      ev = (m_s2[i] != m_prev[i]);
          else if (m_pol[i]) ev = (!m_s2[i] && m_prev[i]);
          else               ev = (m_s2[i] && !m_prev[i]);
          ev = ev && m_en[i];
          nraw[i] = ev || (m_raw[i] && !clr[i]);
        end
      end
      m_raw  <= nraw;
      m_prev <= m_s2;
      m_s2   <= m_s1;
      m_s1   <= pin;
      if (wr_en) begin
        case (addr)
          A_EN:   m_en   <= wdata;
          A_MASK: m_mask <= wdata;
          A_MODE: m_mode <= wdata;
          A_ANY:  m_any  <= wdata;
          A_POL:  m_pol  <= wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #3;
      chk("R7 irq", {31'h0, irq}, {31'h0, |(m_raw & ~m_mask)});
      if (!wr_en && addr == A_RAW) chk("raw R2 R3 R4 R5 R6 R8", rdata, m_raw);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = A_RAW;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
    #1 addr = A_RAW;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_EN,   0, "R1 en");
    rd(A_RAW,  0, "R1 raw");
    rd(A_MSKD, 0, "R1 masked");
    rd(A_MASK, 0, "R1 mask");
    rd(A_MODE, 0, "R1 mode");
    rd(A_ANY,  0, "R1 any");
    rd(A_POL,  0, "R1 pol");
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(8'h00,  0, "R9 unmapped");

    // pin0 rise, pin1 fall, pin2 any, pin3 level high, pin4 level low, pin5 disabled rise
    wr(A_POL, 32'h12);
    wr(A_MODE, 32'h18);
    wr(A_ANY, 32'h04);
    wr(A_EN, 32'h1F);
    idle(3);
    rd(A_RAW, 32'h10, "R5 low level active");
    @(negedge clk) pin = 32'h3F;
    idle(4);
    rd(A_RAW, 32'h0D, "R3 R4 R5 R2 pins high");
    @(negedge clk) pin = 32'h00;
    idle(4);
    rd(A_RAW, 32'h17, "R3 R4 R5 pins low");

    // R6 clear
    wr(A_CLR, 32'h01);
    rd(A_RAW, 32'h16, "R6 partial clear");
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_RAW, 32'h10, "R6 clear all, level kept");

    // R7 mask
    wr(A_MASK, 32'h10);
    rd(A_MSKD, 32'h0, "R7 masked hidden");
    chk("R7 irq masked", {31'h0, irq}, 32'h0);
    wr(A_MASK, 32'h0);
    rd(A_MSKD, 32'h10, "R7 masked visible");
    chk("R7 irq set", {31'h0, irq}, 32'h1);

    // R2 enable gating
    @(negedge clk) pin = 32'h3F;
    idle(4);
    rd(A_RAW, 32'h0D, "R2 before disable");
    wr(A_EN, 32'h0);
    idle(2);
    rd(A_RAW, 32'h05, "R2 latched kept after disable");
    wr(A_CLR, 32'hFFFF_FFFF);
    @(negedge clk) pin = 32'h00;
    idle(3);
    @(negedge clk) pin = 32'h3F;
    idle(4);
    rd(A_RAW, 32'h0, "R2 disabled no latch");

    // R8 latency
    wr(A_EN, 32'h1F);
    @(negedge clk) pin = 32'h00;
    idle(5);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_RAW, 32'h10, "R8 baseline");
    @(negedge clk) pin = 32'h01;
    rd(A_RAW, 32'h10, "R8 one edge");
    rd(A_RAW, 32'h10, "R8 two edges");
    rd(A_RAW, 32'h11, "R8 three edges");

    // R9 register map behaviour
    wr(A_RAW, 32'hFFFF_FFFF);
    wr(A_MSKD, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h0, "R9 mask untouched");
    rd(A_EN, 32'h1F, "R9 en untouched");
    rd(A_RAW, 32'h11, "R9 raw untouched");
    rd(A_CLR, 32'h0, "R9 clear reads zero");
    rd(A_POL, 32'h12, "R9 pol readback");

    // mixed random traffic against the model (R6 same-cycle clears included)
    wr(A_ANY, 32'h0F0F_0F0F);
    wr(A_POL, 32'h3333_3333);
    wr(A_MODE, 32'hF000_000F);
    wr(A_EN, 32'hFFFF_FF0F);
    wr(A_MASK, 32'h00FF_0000);
    for (int k = 0; k < 600; k++) begin
      @(negedge clk) pin = $urandom;
      if (k % 7 == 3) wr(A_CLR, $urandom);
      if (k == 300) wr(A_POL, 32'hCCCC_CCCC);
      if (k == 450) wr(A_MODE, 32'h0000_F0F0);
    end
    wr(A_CLR, 32'hFFFF_FFFF);
    idle(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule